// File: doc/BRIEF.md
# PLL Frequency Lock Detector

This block decides whether a clock synthesizer has settled on its programmed frequency. A programmable divide-by-(N+1) stage turns the source clock into the reference rate. A second divide-by-(M+1) stage turns the VCO clock into the feedback rate. The block does not compare phase. It counts feedback edges over windows of a fixed number of reference periods, so it reaches a verdict sooner when the reference rate is higher.

The block keeps a lock bit that software cannot write. The bit sets only when the count lies within a narrow band around the expected value. Once set, it clears only when the count leaves a wider band, or when no count arrives by the end of the window. Every change of the lock bit sets a sticky flag, and software clears the flag by writing 1 to it. The interrupt request is the flag gated by an enable bit. Writing either divider field clears the lock bit, restarts the window timing and throws away the first full window.

The feedback counter runs in the VCO clock domain. At the end of each window the counter hands its value to the reference side through a toggle request and acknowledge pair.

A controller on the reference side sequences the measurement. Its states are:
- DRAIN: waits for an outstanding handshake to finish. Goes to FLUSH when the handshake is done.
- FLUSH: waits for a window end. On a window end with no handshake outstanding, it requests a capture and goes to DROP. On a window end with a handshake still outstanding, it goes to DRAIN.
- DROP: waits for the acknowledge of the capture it is going to discard. When the acknowledge arrives, it goes to GATHER. If a window ends first, it goes to DRAIN (handshake still outstanding) or to FLUSH (handshake done).
- GATHER: a window is running. On the window end it requests a capture and goes to AWAIT.
- AWAIT: waits for the capture. When the acknowledge arrives, it latches the count and goes to JUDGE. If the window ends first, it records a miss, clears the lock bit, and goes to DRAIN or FLUSH.
- JUDGE: a single cycle that applies the verdict. It then goes to GATHER, or to AWAIT if a window ends in that same cycle.

Any divider write forces the controller to DRAIN. Reset puts it in FLUSH.

Top module: `pll_lock_detect`

## Requirements
- R1: The reference rate is the source clock divided by (refdiv+1). A window lasts WIN_LEN reference periods, which is WIN_LEN*(refdiv+1) source cycles.
- R2: The feedback rate is the VCO clock divided by (fbdiv+1). The count is the number of feedback periods in one window.
- R3: When unlocked, the lock bit sets after a window whose count differs from EXP_CNT by no more than LOCK_TOL.
- R4: A count that is more than LOCK_TOL but no more than UNLOCK_TOL from EXP_CNT leaves the lock bit unchanged, whether it is set or clear.
- R5: When locked, the lock bit clears after a window whose count differs from EXP_CNT by more than UNLOCK_TOL.
- R6: A window that delivers no count, for example because the VCO clock is stopped, clears the lock bit.
- R7: A write to address 0 or 1 clears the lock bit in the next cycle. After such a write, and after reset, the lock bit stays clear for at least the next full window, because that window is discarded.
- R8: Every change of the lock bit, set or clear, sets the sticky flag (status bit 1 at address 3). Writing 1 to that bit clears the flag. Writing 0 to it has no effect. If a lock change and a clear happen in the same cycle, the set wins.
- R9: irq_o equals the flag AND the enable bit (bit 0 at address 2).
- R10: The register map is:
  - address 0: bits [3:0] hold refdiv.
  - address 1: bits [5:0] hold fbdiv.
  - address 2: bit 0 is the enable.
  - address 3: bit 0 is the lock bit and bit 1 is the flag.
  
  Unused bits read 0. A write to bit 0 of address 3 has no effect.
- R11: After reset, every register field, the lock bit, the flag and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src_i | input | 1 | Source clock; register and reference side |
| clk_vco_i | input | 1 | VCO clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | REG_W | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | REG_W | Register read data (combinational) |
| lock_o | output | 1 | Lock bit |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with LOCK_TOL=2 and UNLOCK_TOL=6; every other parameter keeps its default. The sampling boundaries in the handshake can move a count by one. These wider bands keep that uncertainty away from both thresholds, so a VCO set for a count of 68 sits firmly in the hysteresis band and a count of 80 sits firmly outside it. The bench steps the VCO across locked, hysteresis, far-off and stopped settings, and runs the reference divider at 0 and 1. This exercises both window lengths and both directions of the hysteresis.

// File: rtl/lkd_pkg.sv
package lkd_pkg;

    typedef enum logic [2:0] {
        ST_DRAIN  = 3'd0,
        ST_FLUSH  = 3'd1,
        ST_DROP   = 3'd2,
        ST_GATHER = 3'd3,
        ST_AWAIT  = 3'd4,
        ST_JUDGE  = 3'd5
    } lkd_state_e;

    typedef enum logic [1:0] {
        RA_REFDIV = 2'd0,
        RA_FBDIV  = 2'd1,
        RA_CTRL   = 2'd2,
        RA_STAT   = 2'd3
    } lkd_reg_e;

endpackage

// File: rtl/lkd_refdiv.sv
// Reference divider and window timer, source clock domain.
module lkd_refdiv #(
    parameter int REF_W   = 4,
    parameter int WIN_LEN = 64
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    input  logic [REF_W-1:0] ref_div_i,
    output logic             win_end_o
);
    localparam int WIN_W = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;

    logic [REF_W-1:0] pre_cnt_q;
    logic [WIN_W-1:0] win_cnt_q;
    logic             tick;

    assign tick      = (pre_cnt_q >= ref_div_i);
    assign win_end_o = tick && (win_cnt_q == WIN_W'(WIN_LEN - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pre_cnt_q <= '0;
            win_cnt_q <= '0;
        end else if (restart_i) begin
            pre_cnt_q <= '0;
            win_cnt_q <= '0;
        end else begin
            pre_cnt_q <= tick ? '0 : pre_cnt_q + 1'b1;
            if (tick) begin
                win_cnt_q <= win_end_o ? '0 : win_cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lkd_fbcount.sv
// Feedback divider and edge counter, VCO clock domain.
module lkd_fbcount #(
    parameter int FB_W  = 6,
    parameter int CNT_W = 10
) (
    input  logic             clk_vco_i,
    input  logic             rst_ni,
    input  logic [FB_W-1:0]  fb_div_i,
    input  logic             req_tgl_i,
    output logic             ack_tgl_o,
    output logic [CNT_W-1:0] count_o
);
    logic [1:0]       rst_sync_q;
    logic             vrst_n;
    logic [2:0]       req_sync_q;
    logic             capture;
    logic [FB_W-1:0]  div_cnt_q;
    logic             fb_pulse;
    logic [CNT_W-1:0] edges_q;
    logic [CNT_W-1:0] edges_inc;

    // Local reset release, synchronised to the VCO clock.
    always_ff @(posedge clk_vco_i or negedge rst_ni) begin
        if (!rst_ni) rst_sync_q <= '0;
        else         rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
    assign vrst_n = rst_sync_q[1];

    assign capture   = req_sync_q[2] ^ req_sync_q[1];
    assign fb_pulse  = (div_cnt_q >= fb_div_i);
    assign edges_inc = (fb_pulse && (edges_q != '1)) ? edges_q + 1'b1 : edges_q;

    always_ff @(posedge clk_vco_i or negedge vrst_n) begin
        if (!vrst_n) begin
            req_sync_q <= '0;
            div_cnt_q  <= '0;
            edges_q    <= '0;
            count_o    <= '0;
            ack_tgl_o  <= 1'b0;
        end else begin
            req_sync_q <= {req_sync_q[1:0], req_tgl_i};
            div_cnt_q  <= fb_pulse ? '0 : div_cnt_q + 1'b1;
            if (capture) begin
                count_o   <= edges_inc;
                edges_q   <= '0;
                ack_tgl_o <= req_sync_q[1];
            end else begin
                edges_q   <= edges_inc;
            end
        end
    end

endmodule

// File: rtl/lkd_judge.sv
// Measurement sequencer and lock verdict, source clock domain.
module lkd_judge
    import lkd_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int EXP_CNT    = 64,
    parameter int LOCK_TOL   = 1,
    parameter int UNLOCK_TOL = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             restart_i,
    input  logic             win_end_i,
    input  logic             ack_tgl_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             flag_clr_i,
    output logic             req_tgl_o,
    output logic             lock_o,
    output logic             flag_o
);
    localparam logic [CNT_W-1:0] EXP_V = CNT_W'(EXP_CNT);
    localparam logic [CNT_W-1:0] LTOL  = CNT_W'(LOCK_TOL);
    localparam logic [CNT_W-1:0] UTOL  = CNT_W'(UNLOCK_TOL);

    lkd_state_e       state_q, state_d;
    logic [1:0]       ack_sync_q;
    logic             outst;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] dev;
    logic             fire_req, take, miss, lock_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ack_sync_q <= '0;
        else         ack_sync_q <= {ack_sync_q[0], ack_tgl_i};
    end
    assign outst = req_tgl_o ^ ack_sync_q[1];

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_FLUSH;
        else         state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (restart_i) begin
            state_d = ST_DRAIN;
        end else begin
            unique case (state_q)
                ST_DRAIN:  if (!outst) state_d = ST_FLUSH;
                ST_FLUSH:  if (win_end_i) state_d = outst ? ST_DRAIN : ST_DROP;
                ST_DROP: begin
                    if (win_end_i)   state_d = outst ? ST_DRAIN : ST_FLUSH;
                    else if (!outst) state_d = ST_GATHER;
                end
                ST_GATHER: if (win_end_i) state_d = ST_AWAIT;
                ST_AWAIT: begin
                    if (win_end_i)   state_d = outst ? ST_DRAIN : ST_FLUSH;
                    else if (!outst) state_d = ST_JUDGE;
                end
                ST_JUDGE:  state_d = win_end_i ? ST_AWAIT : ST_GATHER;
                default:   state_d = ST_DRAIN;
            endcase
        end
    end

    // Output decisions
    always_comb begin
        fire_req = !restart_i && win_end_i &&
                   (((state_q == ST_FLUSH) && !outst) ||
                    (state_q == ST_GATHER) || (state_q == ST_JUDGE));
        take     = !restart_i && (state_q == ST_AWAIT) && !win_end_i && !outst;
        miss     = !restart_i && (state_q == ST_AWAIT) && win_end_i;
        dev      = (cnt_q >= EXP_V) ? (cnt_q - EXP_V) : (EXP_V - cnt_q);
        lock_d   = lock_o;
        if (restart_i || miss) begin
            lock_d = 1'b0;
        end else if (state_q == ST_JUDGE) begin
            if (!lock_o && (dev <= LTOL)) lock_d = 1'b1;
            if (lock_o && (dev > UTOL))   lock_d = 1'b0;
        end
    end

    // Output registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            req_tgl_o <= 1'b0;
            cnt_q     <= '0;
            lock_o    <= 1'b0;
            flag_o    <= 1'b0;
        end else begin
            req_tgl_o <= req_tgl_o ^ fire_req;
            if (take) cnt_q <= count_i;
            lock_o    <= lock_d;
            flag_o    <= (flag_o && !flag_clr_i) || (lock_d != lock_o);
        end
    end

endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
    import lkd_pkg::*;
#(
    parameter int REF_W      = 4,
    parameter int FB_W       = 6,
    parameter int REG_W      = 6,
    parameter int WIN_LEN    = 64,
    parameter int EXP_CNT    = 64,
    parameter int LOCK_TOL   = 1,
    parameter int UNLOCK_TOL = 3,
    parameter int CNT_W      = 10
) (
    input  logic             clk_src_i,
    input  logic             clk_vco_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [1:0]       wr_addr_i,
    input  logic [REG_W-1:0] wr_data_i,
    input  logic [1:0]       rd_addr_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             lock_o,
    output logic             irq_o
);
    logic [REF_W-1:0] ref_div_q;
    logic [FB_W-1:0]  fb_div_q;
    logic             irq_en_q;
    logic             irq_flag;
    logic             wr_ref, wr_fb, wr_ctrl, wr_stat;
    logic             restart, flag_clr;
    logic             win_end, req_tgl, ack_tgl;
    logic [CNT_W-1:0] fb_count;

    assign wr_ref   = wr_en_i && (wr_addr_i == RA_REFDIV);
    assign wr_fb    = wr_en_i && (wr_addr_i == RA_FBDIV);
    assign wr_ctrl  = wr_en_i && (wr_addr_i == RA_CTRL);
    assign wr_stat  = wr_en_i && (wr_addr_i == RA_STAT);
    assign restart  = wr_ref || wr_fb;
    assign flag_clr = wr_stat && wr_data_i[1];

    always_ff @(posedge clk_src_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ref_div_q <= '0;
            fb_div_q  <= '0;
            irq_en_q  <= 1'b0;
        end else begin
            if (wr_ref)  ref_div_q <= wr_data_i[REF_W-1:0];
            if (wr_fb)   fb_div_q  <= wr_data_i[FB_W-1:0];
            if (wr_ctrl) irq_en_q  <= wr_data_i[0];
        end
    end

    always_comb begin
        rd_data_o = '0;
        unique case (lkd_reg_e'(rd_addr_i))
            RA_REFDIV: rd_data_o[REF_W-1:0] = ref_div_q;
            RA_FBDIV:  rd_data_o[FB_W-1:0]  = fb_div_q;
            RA_CTRL:   rd_data_o[0]         = irq_en_q;
            RA_STAT:   rd_data_o[1:0]       = {irq_flag, lock_o};
            default:   rd_data_o            = '0;
        endcase
    end

    assign irq_o = irq_flag && irq_en_q;

    lkd_refdiv #(.REF_W(REF_W), .WIN_LEN(WIN_LEN)) refdiv_i (
        .clk_i     (clk_src_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .ref_div_i (ref_div_q),
        .win_end_o (win_end)
    );

    lkd_fbcount #(.FB_W(FB_W), .CNT_W(CNT_W)) fbcount_i (
        .clk_vco_i (clk_vco_i),
        .rst_ni    (rst_ni),
        .fb_div_i  (fb_div_q),
        .req_tgl_i (req_tgl),
        .ack_tgl_o (ack_tgl),
        .count_o   (fb_count)
    );

    lkd_judge #(
        .CNT_W(CNT_W), .EXP_CNT(EXP_CNT),
        .LOCK_TOL(LOCK_TOL), .UNLOCK_TOL(UNLOCK_TOL)
    ) judge_i (
        .clk_i      (clk_src_i),
        .rst_ni     (rst_ni),
        .restart_i  (restart),
        .win_end_i  (win_end),
        .ack_tgl_i  (ack_tgl),
        .count_i    (fb_count),
        .flag_clr_i (flag_clr),
        .req_tgl_o  (req_tgl),
        .lock_o     (lock_o),
        .flag_o     (irq_flag)
    );

endmodule

// File: rtl/lkd_chk.sv
module lkd_chk #(
    parameter int REG_W = 6
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_en_i,
    input logic [1:0]       wr_addr_i,
    input logic [REG_W-1:0] wr_data_i,
    input logic             lock_i,
    input logic             flag_i,
    input logic             ie_i,
    input logic             irq_i
);
    // R9
    irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |-> (flag_i && ie_i));

    // R8
    toggle_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(lock_i) |-> flag_i);

    // R8
    flag_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flag_i) |-> !$stable(lock_i));

    // R8
    flag_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && (wr_addr_i == 2'd3) && wr_data_i[1]) |=> (!flag_i || !$stable(lock_i)));

    // R7
    div_write_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !wr_addr_i[1]) |=> !lock_i);

endmodule

bind pll_lock_detect lkd_chk #(.REG_W(REG_W)) chk_i (
    .clk_i     (clk_src_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .lock_i    (lock_o),
    .flag_i    (irq_flag),
    .ie_i      (irq_en_q),
    .irq_i     (irq_o)
);

// File: tb/pll_lock_detect_tb_top.sv
`timescale 1ns/1ps
module pll_lock_detect_tb_top;
    logic       clk_src = 1'b0;
    logic       clk_vco = 1'b0;
    logic       rst_n   = 1'b0;
    logic       wr_en   = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [5:0] wr_data = '0;
    logic [1:0] rd_addr = 2'd3;
    logic [5:0] rd_data;
    logic       lock, irq;

    realtime vco_half = 1.25;
    bit      vco_run  = 1'b0;
    int      n_chk = 0, n_err = 0;

    // model state
    bit         model_on = 1'b0;
    bit         m_ie = 1'b0, m_flag = 1'b0, m_lock_prev = 1'b0;
    logic       wq_en = 1'b0;
    logic [1:0] wq_addr = '0;
    logic [5:0] wq_data = '0;

    always #5 clk_src = ~clk_src;

    always begin
        if (vco_run) begin
            #(vco_half);
            clk_vco = ~clk_vco;
        end else begin
            #7;
        end
    end

    pll_lock_detect #(.LOCK_TOL(2), .UNLOCK_TOL(6)) dut_i (
        .clk_src_i (clk_src),
        .clk_vco_i (clk_vco),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .lock_o    (lock),
        .irq_o     (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk_src) begin
        wq_en   <= wr_en;
        wq_addr <= wr_addr;
        wq_data <= wr_data;
    end

    // Per-clock reference model of flag, enable and interrupt
    always @(negedge clk_src) begin
        if (model_on) begin
            if (wq_en && wq_addr == 2'd2) m_ie = wq_data[0];
            if (wq_en && wq_addr == 2'd3 && wq_data[1]) m_flag = 1'b0;
            if (lock !== m_lock_prev) m_flag = 1'b1;
            m_lock_prev = lock;
            if (rd_addr == 2'd3) begin
                chk("R8 flag", int'(rd_data[1]), int'(m_flag));
                chk("R10 lock readback", int'(rd_data[0]), int'(lock));
            end
            chk("R9 irq", int'(irq), int'(m_flag && m_ie));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [5:0] d);
        @(negedge clk_src);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk_src);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk_src);
        #2 rd_addr = a;
        #1 v = int'(rd_data);
        rd_addr = 2'd3;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk_src);
    endtask

    task automatic set_vco(input realtime period);
        vco_half = period / 2.0;
        vco_run  = 1'b1;
    endtask

    initial begin
        #(10.0 * 150000);
        n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int v;
        cyc(5);
        chk("R11 lock in reset", int'(lock), 0);
        chk("R11 irq in reset", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk_src);
        model_on = 1'b1;
        rd(2'd0, v); chk("R11 refdiv reset", v, 0);
        rd(2'd1, v); chk("R11 fbdiv reset", v, 0);
        rd(2'd2, v); chk("R11 enable reset", v, 0);

        // fbdiv=0: feedback runs at full VCO rate, count 256, no lock
        set_vco(2.5);
        cyc(300);
        chk("R2 undivided feedback no lock", int'(lock), 0);

        wr(2'd2, 6'd1);
        wr(2'd1, 6'd3);
        rd(2'd1, v); chk("R10 fbdiv readback", v, 3);
        cyc(100);
        chk("R7 first window discarded", int'(lock), 0);
        cyc(120);
        chk("R3 lock at count 64", int'(lock), 1);
        chk("R9 irq after lock", int'(irq), 1);

        wr(2'd3, 6'd1);
        cyc(2);
        chk("R10 lock bit read-only", int'(lock), 1);
        rd(2'd3, v); chk("R8 write 0 keeps flag", (v >> 1) & 1, 1);
        wr(2'd3, 6'd2);
        cyc(2);
        chk("R8 w1c clears irq", int'(irq), 0);

        // count 68: inside hysteresis band, stays locked
        set_vco(2.5 * 64.0 / 68.0);
        cyc(5 * 64);
        chk("R4 locked holds at 68", int'(lock), 1);
        chk("R4 no toggle no irq", int'(irq), 0);

        // count 80: outside unlock tolerance
        set_vco(2.0);
        cyc(3 * 64);
        chk("R5 unlock at 80", int'(lock), 0);
        chk("R8 unlock raises irq", int'(irq), 1);

        wr(2'd3, 6'd2);
        set_vco(2.5 * 64.0 / 68.0);
        cyc(5 * 64);
        chk("R4 unlocked holds at 68", int'(lock), 0);

        set_vco(2.5);
        cyc(4 * 64);
        chk("R3 relock at 64", int'(lock), 1);

        // enable off, VCO stopped
        wr(2'd2, 6'd0);
        vco_run = 1'b0;
        cyc(3 * 64);
        chk("R6 stopped vco unlocks", int'(lock), 0);
        chk("R9 masked irq", int'(irq), 0);
        rd(2'd3, v); chk("R8 flag set while masked", (v >> 1) & 1, 1);

        vco_run = 1'b1;
        cyc(4 * 64);
        chk("R3 lock after vco restart", int'(lock), 1);
        wr(2'd3, 6'd2);

        // refdiv=1: window 128 source cycles, VCO 5 ns gives count 64
        wr(2'd0, 6'd1);
        chk("R7 divider write unlocks", int'(lock), 0);
        set_vco(5.0);
        cyc(200);
        chk("R7 discard at refdiv 1", int'(lock), 0);
        cyc(250);
        chk("R1 lock with refdiv 1", int'(lock), 1);

        set_vco(2.5);
        cyc(3 * 128);
        chk("R1 count 128 unlocks at refdiv 1", int'(lock), 0);

        model_on = 1'b0;
        rst_n = 1'b0;
        cyc(3);
        chk("R11 lock after reset", int'(lock), 0);
        rd(2'd0, v); chk("R11 refdiv after reset", v, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule